// File: doc/BRIEF.md
# USB Host Command and Port-Reset Controller

This block holds the command bits of a simple USB 1.x host controller and sequences its resets. Software sets or clears a run bit, which gates schedule execution. When it clears the bit, the block waits for the transaction in flight to end and only then raises a halted flag. A fatal error of either kind clears the run bit without software.

A controller reset is a single-cycle internal pulse. It aborts the bus activity, and each port sees a forced disconnect that sets its change flags. The port then counts a fixed number of bit-time ticks and samples its attach and low-speed pins again. A global reset drives reset onto the bus and holds all other state at its power-on value until software clears it. The chip reset input has the same effect without the bus drive.

Top module: `usbh_cmd_reset_ctrl`

## Requirements
- R1: After chip reset, `cmd_rdata` is 0, `halted` is 1, `sched_en` and `bus_greset` are 0, and every port status word is 0. Each port then starts its detect countdown.
- R2: The command word has run at bit 0, controller reset at bit 1 and global reset at bit 2. Writing 1 to bit 0 makes run read 1 after the write edge. `halted` falls one cycle later.
- R3: When run is cleared while `xact_busy` is 1, `halted` stays 0. It rises on the edge after the first cycle in which `xact_busy` is 0.
- R4: If `err_consist` or `err_bus` is high in a cycle, run reads 0 after that edge. This holds even if the same cycle writes 1 to run.
- R5: Writing 1 to bit 1 makes the controller-reset bit read 1 for exactly one cycle. Hardware then clears it, and run reads 0 and `halted` reads 1.
- R6: The port status word has connect at bit 0, connect-change at bit 1, enable at bit 2, enable-change at bit 3 and low-speed at bit 8; the other bits read 0. At the end of the controller-reset cycle, every port reads connect 0, enable 0, low-speed 0, connect-change 1 and enable-change 1, whether or not a device is attached.
- R7: After a chip reset, global reset or controller reset, connect stays 0 until the DETECT_TICKS-th `bit_tick`. On that tick the port samples attach and low-speed, and it sets connect-change if a device is attached.
- R8: Once detected, a port follows its attach pin each cycle. Low-speed equals attach AND the low-speed pin, and any change of attach sets connect-change. A detach while enabled clears enable and sets enable-change.
- R9: A port write clears connect-change when bit 1 is 1 and enable-change when bit 3 is 1; writing 0 to these bits leaves them unchanged. Enable takes bit 2 only while connect is 1.
- R10: While global reset reads 1, `bus_greset` is 1 and the port words are 0. Writes to run and controller reset are ignored until software writes 0 to bit 2.
- R11: `sched_en` is 1 only while run is 1 and neither controller reset nor global reset reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 3 | Command write data: {global reset, controller reset, run} |
| port_wr | input | 1 | Port status write strobe |
| port_sel | input | PSEL_W | Index of the port being written |
| port_wdata | input | 9 | Port status write data |
| xact_busy | input | 1 | A bus transaction is in progress |
| err_consist | input | 1 | Consistency-check failure strobe |
| err_bus | input | 1 | System bus error strobe |
| bit_tick | input | 1 | One pulse per bus bit time |
| dev_attach | input | NUM_PORTS | Raw attach per port |
| dev_lowspd | input | NUM_PORTS | Raw low-speed detect per port |
| cmd_rdata | output | 3 | Command word read value |
| halted | output | 1 | Controller has stopped |
| port_rdata | output | 9*NUM_PORTS | Port status words, port i at [9*i +: 9] |
| bus_greset | output | 1 | Drives global reset on the bus |
| sched_en | output | 1 | Schedule execution allowed |

## Verification
Suppose the halt logic misses the end of a transaction. Then `halted` stays 0 past the cycle after `xact_busy` falls, which is visible one edge later. A detect counter that is not cleared by a controller reset shows up as a connect bit rising before the DETECT_TICKS-th tick. A forced disconnect that skips a field leaves a wrong status word on the cycle right after the reset pulse. Write-1-to-clear errors show as a flag that stays set or clears on a zero write.

// File: rtl/usbh_cr_pkg.sv
package usbh_cr_pkg;
    localparam int PSW_W = 9;
    localparam int F_CCS = 0;
    localparam int F_CSC = 1;
    localparam int F_EN  = 2;
    localparam int F_PEC = 3;
    localparam int F_LS  = 8;

    typedef enum logic {P_WAIT, P_LIVE} port_st_e;

    typedef struct packed {
        logic run;
        logic hcr;
        logic gr;
        logic halted;
    } cmd_state_t;
endpackage

// File: rtl/usbh_cmd_core.sv
module usbh_cmd_core
    import usbh_cr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [2:0] wdata,
    input  logic       busy,
    input  logic       fatal,
    output cmd_state_t st
);
    cmd_state_t d, q;

    always_comb begin
        d = q;
        if (q.gr || q.hcr) begin
            d.run    = 1'b0;
            d.hcr    = 1'b0;
            d.halted = 1'b1;
            if (wr) d.gr = wdata[2];
        end else begin
            if (wr) begin
                d.gr  = wdata[2];
                d.hcr = wdata[1] & ~wdata[2];
                d.run = wdata[0] & ~wdata[2];
            end
            if (fatal) d.run = 1'b0;
            d.halted = q.run ? 1'b0 : (q.halted | ~busy);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{run: 1'b0, hcr: 1'b0, gr: 1'b0, halted: 1'b1};
        else        q <= d;
    end

    assign st = q;
endmodule

// File: rtl/usbh_port_fsm.sv
module usbh_port_fsm
    import usbh_cr_pkg::*;
#(
    parameter int DETECT_TICKS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             vdisc,
    input  logic             tick,
    input  logic             attach,
    input  logic             lowspd,
    input  logic             wr,
    input  logic [PSW_W-1:0] wdata,
    output logic [PSW_W-1:0] stat
);
    localparam int CW = $clog2(DETECT_TICKS + 1);

    typedef struct packed {
        port_st_e        st;
        logic [CW-1:0]   cnt;
        logic            ccs;
        logic            csc;
        logic            en;
        logic            pec;
        logic            ls;
    } port_t;

    port_t d, q;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else if (vdisc) begin
            d.st  = P_WAIT;
            d.cnt = '0;
            d.ccs = 1'b0;
            d.en  = 1'b0;
            d.ls  = 1'b0;
            d.csc = 1'b1;
            d.pec = 1'b1;
        end else begin
            if (wr) begin
                if (wdata[F_CSC]) d.csc = 1'b0;
                if (wdata[F_PEC]) d.pec = 1'b0;
                d.en = wdata[F_EN] & q.ccs;
            end
            if (q.st == P_WAIT) begin
                if (tick) begin
                    if (q.cnt == CW'(DETECT_TICKS - 1)) begin
                        d.st  = P_LIVE;
                        d.cnt = '0;
                        d.ccs = attach;
                        d.ls  = attach & lowspd;
                        if (attach) d.csc = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end else begin
                d.ccs = attach;
                d.ls  = attach & lowspd;
                if (attach != q.ccs) d.csc = 1'b1;
                if (!attach && q.en) begin
                    d.en  = 1'b0;
                    d.pec = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        stat        = '0;
        stat[F_CCS] = q.ccs;
        stat[F_CSC] = q.csc;
        stat[F_EN]  = q.en;
        stat[F_PEC] = q.pec;
        stat[F_LS]  = q.ls;
    end
endmodule

// File: rtl/usbh_cmd_reset_ctrl.sv
module usbh_cmd_reset_ctrl
    import usbh_cr_pkg::*;
#(
    parameter int NUM_PORTS    = 2,
    parameter int DETECT_TICKS = 64,
    localparam int PSEL_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_wr,
    input  logic [2:0]                 cmd_wdata,
    input  logic                       port_wr,
    input  logic [PSEL_W-1:0]          port_sel,
    input  logic [PSW_W-1:0]           port_wdata,
    input  logic                       xact_busy,
    input  logic                       err_consist,
    input  logic                       err_bus,
    input  logic                       bit_tick,
    input  logic [NUM_PORTS-1:0]       dev_attach,
    input  logic [NUM_PORTS-1:0]       dev_lowspd,
    output logic [2:0]                 cmd_rdata,
    output logic                       halted,
    output logic [PSW_W*NUM_PORTS-1:0] port_rdata,
    output logic                       bus_greset,
    output logic                       sched_en
);
    cmd_state_t cst;

    usbh_cmd_core u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cmd_wr),
        .wdata (cmd_wdata),
        .busy  (xact_busy),
        .fatal (err_consist | err_bus),
        .st    (cst)
    );

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        usbh_port_fsm #(.DETECT_TICKS(DETECT_TICKS)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (cst.gr),
            .vdisc  (cst.hcr),
            .tick   (bit_tick),
            .attach (dev_attach[i]),
            .lowspd (dev_lowspd[i]),
            .wr     (port_wr && (port_sel == PSEL_W'(i))),
            .wdata  (port_wdata),
            .stat   (port_rdata[PSW_W*i +: PSW_W])
        );
    end

    assign cmd_rdata  = {cst.gr, cst.hcr, cst.run};
    assign halted     = cst.halted;
    assign bus_greset = cst.gr;
    assign sched_en   = cst.run & ~cst.hcr & ~cst.gr;
endmodule

// File: rtl/usbh_cmd_reset_chk.sv
module usbh_cmd_reset_chk #(
    parameter int NUM_PORTS = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   xact_busy,
    input logic                   err_consist,
    input logic                   err_bus,
    input logic [2:0]             cmd_rdata,
    input logic                   halted,
    input logic [9*NUM_PORTS-1:0] port_rdata,
    input logic                   bus_greset
);
    AST_HALT_WAITS_XACT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_rdata[0] && !cmd_rdata[1] && !bus_greset && xact_busy && !halted) |=> !halted); // R3

    AST_FATAL_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (err_consist || err_bus) |=> !cmd_rdata[0]); // R4

    AST_HCR_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdata[1] |=> (!cmd_rdata[1] && !cmd_rdata[0] && halted)); // R5

    AST_GRESET_PORTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_greset |=> (port_rdata == '0)); // R10

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
        AST_VDISC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_rdata[1] && !bus_greset) |=> (port_rdata[9*i +: 9] == 9'h00A)); // R6
    end
endmodule

bind usbh_cmd_reset_ctrl usbh_cmd_reset_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xact_busy   (xact_busy),
    .err_consist (err_consist),
    .err_bus     (err_bus),
    .cmd_rdata   (cmd_rdata),
    .halted      (halted),
    .port_rdata  (port_rdata),
    .bus_greset  (bus_greset)
);

// File: tb/usbh_cmd_reset_ctrl_tb.sv
module usbh_cmd_reset_ctrl_tb;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [2:0]    cmd_wdata = '0;
    logic          port_wr = 1'b0;
    logic [0:0]    port_sel = '0;
    logic [8:0]    port_wdata = '0;
    logic          xact_busy = 1'b0;
    logic          err_consist = 1'b0;
    logic          err_bus = 1'b0;
    logic          bit_tick = 1'b0;
    logic [NP-1:0] dev_attach = 2'b11;
    logic [NP-1:0] dev_lowspd = 2'b10;
    logic [2:0]    cmd_rdata;
    logic          halted;
    logic [9*NP-1:0] port_rdata;
    logic          bus_greset;
    logic          sched_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    usbh_cmd_reset_ctrl #(.NUM_PORTS(NP), .DETECT_TICKS(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .port_wr(port_wr), .port_sel(port_sel), .port_wdata(port_wdata),
        .xact_busy(xact_busy), .err_consist(err_consist), .err_bus(err_bus),
        .bit_tick(bit_tick), .dev_attach(dev_attach), .dev_lowspd(dev_lowspd),
        .cmd_rdata(cmd_rdata), .halted(halted), .port_rdata(port_rdata),
        .bus_greset(bus_greset), .sched_en(sched_en)
    );

    // kinds: 0 cmd, 1 halted, 2 sched_en, 3 bus_greset, 4 port0, 5 port1
    typedef struct {
        int         kind;
        logic [8:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];

    task automatic expect_val(int kind, logic [8:0] exp, string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    function automatic logic [8:0] observe(int kind);
        case (kind)
            0: return {6'd0, cmd_rdata};
            1: return {8'd0, halted};
            2: return {8'd0, sched_en};
            3: return {8'd0, bus_greset};
            4: return port_rdata[8:0];
            default: return port_rdata[17:9];
        endcase
    endfunction

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [8:0] act;
            it  = sb.pop_front();
            act = observe(it.kind);
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic cmd_write(logic [2:0] v);
        cmd_wr = 1'b1; cmd_wdata = v; step(); cmd_wr = 1'b0;
    endtask

    task automatic port_write(int p, logic [8:0] v);
        port_wr = 1'b1; port_sel = 1'(p); port_wdata = v; step(); port_wr = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            bit_tick = 1'b1; step(); bit_tick = 1'b0; step();
        end
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        expect_val(0, 9'h000, "R1"); expect_val(1, 9'h001, "R1");
        expect_val(2, 9'h000, "R1"); expect_val(3, 9'h000, "R1");
        expect_val(4, 9'h000, "R1"); expect_val(5, 9'h000, "R1");
        settle();

        // R7 initial detect countdown
        ticks(63);
        expect_val(4, 9'h000, "R7 before last tick"); settle();
        ticks(1);
        expect_val(4, 9'h003, "R7 port0 detect");
        expect_val(5, 9'h103, "R7 port1 low-speed detect"); settle();

        // R9 write-1-to-clear and enable
        port_write(0, 9'h004);
        expect_val(4, 9'h007, "R9 zero leaves flag, enable set"); settle();
        port_write(0, 9'h006);
        expect_val(4, 9'h005, "R9 one clears flag"); settle();

        // R2 run
        cmd_write(3'b001);
        expect_val(0, 9'h001, "R2 run bit"); expect_val(2, 9'h001, "R11 sched_en");
        expect_val(1, 9'h001, "R2 halted lags"); settle();
        step();
        expect_val(1, 9'h000, "R2 halted falls"); settle();

        // R3 stop waits for transaction
        xact_busy = 1'b1;
        cmd_write(3'b000);
        expect_val(2, 9'h000, "R11 stopped");
        step(); step(); step();
        expect_val(1, 9'h000, "R3 still busy"); settle();
        xact_busy = 1'b0;
        step();
        expect_val(1, 9'h001, "R3 halted after busy"); settle();

        // R4 fatal errors override write
        err_bus = 1'b1; cmd_write(3'b001); err_bus = 1'b0;
        expect_val(0, 9'h000, "R4 bus error"); settle();
        cmd_write(3'b001);
        err_consist = 1'b1; step(); err_consist = 1'b0;
        expect_val(0, 9'h000, "R4 consistency error"); settle();

        // R5/R6 controller reset
        cmd_write(3'b011);
        expect_val(0, 9'h003, "R5 reset bit visible");
        expect_val(2, 9'h000, "R11 gated by reset"); settle();
        step();
        expect_val(0, 9'h000, "R5 self clear"); expect_val(1, 9'h001, "R5 halted");
        expect_val(4, 9'h00A, "R6 port0 vdisc"); expect_val(5, 9'h00A, "R6 port1 vdisc");
        settle();
        ticks(63);
        expect_val(4, 9'h00A, "R7 no early detect"); settle();
        ticks(1);
        expect_val(4, 9'h00B, "R7 port0 redetect");
        expect_val(5, 9'h10B, "R7 port1 redetect"); settle();

        // R8 live tracking
        port_write(0, 9'h00A);
        expect_val(4, 9'h001, "R9 clear both flags"); settle();
        port_write(0, 9'h004);
        expect_val(4, 9'h005, "R9 enable"); settle();
        dev_attach[0] = 1'b0; step();
        expect_val(4, 9'h00A, "R8 detach"); settle();
        port_write(0, 9'h004);
        expect_val(4, 9'h00A, "R9 enable refused when disconnected"); settle();
        dev_lowspd[1] = 1'b0; step();
        expect_val(5, 9'h00B, "R8 low-speed follows pin"); settle();
        dev_lowspd[1] = 1'b1; step();

        // R10 global reset
        cmd_write(3'b101);
        expect_val(0, 9'h004, "R10 global only"); expect_val(3, 9'h001, "R10 bus drive");
        expect_val(2, 9'h000, "R11 gated by global"); settle();
        step();
        expect_val(4, 9'h000, "R10 port0 cleared"); expect_val(5, 9'h000, "R10 port1 cleared");
        expect_val(1, 9'h001, "R10 halted"); settle();
        cmd_write(3'b111);
        expect_val(0, 9'h004, "R10 writes ignored"); settle();
        cmd_write(3'b000);
        expect_val(3, 9'h000, "R10 bus released"); settle();
        ticks(64);
        expect_val(4, 9'h000, "R7 detached stays clear");
        expect_val(5, 9'h103, "R7 after global reset"); settle();

        step();
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule